// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter with Parallel Load

This block is a binary counter whose direction is chosen by which of two strobe lines is pulsed, not by a direction select. Both strobe lines idle high. A low pulse on the up strobe, ending in a rising edge, adds one to the count. A low pulse on the down strobe, ending in a rising edge, subtracts one. The other line stays high during the pulse. The count wraps at both ends.

A parallel data word can be loaded at any time through an active-low load input. Loading needs no count pulse. After load is released, counting resumes from the loaded value. An active-high clear forces zero and wins over load. Two active-low outputs are provided for cascading:
- the carry output goes low while the count is all ones and the up strobe is low;
- the borrow output goes low while the count is zero and the down strobe is low.

The block runs on one system clock. The strobe lines are treated as asynchronous and pass through a synchronizer of `SYNC_STAGES` flops. Each strobe level must last at least two system clocks. Clear, load and data are synchronous to the system clock and act on the next clock edge.

Top module: `updn_dual_strobe_counter`

## Requirements
- R1: After reset the count is zero and both carry_n_o and borrow_n_o are high.
- R2: Each rising edge of up_strobe_i, with dn_strobe_i high, increases the count by one. The new value appears on q_o SYNC_STAGES+1 clock edges after the strobe rises.
- R3: Each rising edge of dn_strobe_i, with up_strobe_i high, decreases the count by one, with the same latency as R2.
- R4: The count wraps: one up step from all ones gives zero, and one down step from zero gives all ones.
- R5: While load_n_i is low, the count takes data_i at the next clock edge. After load_n_i returns high, the loaded value is kept and later steps start from it.
- R6: While load_n_i is low, strobe edges do not change the loaded count.
- R7: While clear_i is high, the count becomes zero at the next clock edge, even if load_n_i is low.
- R8: carry_n_o is low exactly when the count is all ones and the synchronized up strobe is low; otherwise it is high.
- R9: borrow_n_o is low exactly when the count is zero and the synchronized down strobe is low; otherwise it is high.
- R10: If rising edges of both strobes reach the counter in the same clock cycle, the count is unchanged.
- R11: q_o bit 0 is the least significant count bit and bit WIDTH-1 the most significant. Loading 4'b0001 sets only bit 0, and loading 4'b1000 sets only bit 3.
- R12: A falling edge of either strobe does not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clear_i | input | 1 | Active-high clear; takes priority over load |
| load_n_i | input | 1 | Active-low parallel load |
| data_i | input | WIDTH | Parallel load value |
| up_strobe_i | input | 1 | Count-up strobe, idles high, counts on its rising edge |
| dn_strobe_i | input | 1 | Count-down strobe, idles high, counts on its rising edge |
| q_o | output | WIDTH | Count value, bit 0 least significant |
| carry_n_o | output | 1 | Active-low carry: count all ones while up strobe is low |
| borrow_n_o | output | 1 | Active-low borrow: count zero while down strobe is low |

## Verification
The counter is tried with three kinds of stimulus:
- Full sweeps of up pulses and down pulses through all sixteen values. These separate a correct increment or decrement from a wrong step size, and show the wrap at each end.
- A load of every value, each followed by one up pulse and one down pulse. This shows that counting resumes from the loaded value, and it reveals any bit-order swap.
- Strobes pulsed while load is held, clear raised during load, and both strobes released together. These show that load blocks counting, that clear wins over load, and that coincident edges cancel.

While each strobe is held low, the count is checked to be unchanged and the carry and borrow levels are compared with values the bench computes.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic [2:0] {
    ACT_HOLD  = 3'd0,
    ACT_CLEAR = 3'd1,
    ACT_LOAD  = 3'd2,
    ACT_INC   = 3'd3,
    ACT_DEC   = 3'd4
  } cnt_act_e;
endpackage

// File: rtl/strobe_edge_det.sv
module strobe_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_s_o,
  output logic rise_o
);
  logic prev_q;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign line_s_o = line_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain_q;
      logic [SYNC_STAGES-1:0] chain_d;
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
          assign chain_d[i] = line_i;
        end else begin : g_rest
          assign chain_d[i] = chain_q[i-1];
        end
      end
      // idle level of the strobes is high: reset to one so no edge follows reset
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
      end
      assign line_s_o = chain_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= line_s_o;
  end

  assign rise_o = line_s_o & ~prev_q;

  // R2
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/count_core.sv
module count_core
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             load_n_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             up_rise_i,
  input  logic             dn_rise_i,
  output logic [WIDTH-1:0] cnt_o
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  cnt_act_e         act;
  logic             cnt_en;
  logic [WIDTH-1:0] cnt_d;
  logic [WIDTH-1:0] cnt_q;

  always_comb begin
    if (clear_i)                    act = ACT_CLEAR;
    else if (!load_n_i)             act = ACT_LOAD;
    else if (up_rise_i && !dn_rise_i) act = ACT_INC;
    else if (dn_rise_i && !up_rise_i) act = ACT_DEC;
    else                            act = ACT_HOLD;
  end

  always_comb begin
    cnt_en = 1'b1;
    unique case (act)
      ACT_CLEAR: cnt_d = '0;
      ACT_LOAD:  cnt_d = data_i;
      ACT_INC:   cnt_d = cnt_q + ONE;
      ACT_DEC:   cnt_d = cnt_q - ONE;
      default: begin
        cnt_d  = cnt_q;
        cnt_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q == '0));
  // R5
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !load_n_i) |=> (cnt_q == $past(data_i)));
  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && load_n_i && up_rise_i && !dn_rise_i) |=> (cnt_q == $past(cnt_q) + ONE));
  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && load_n_i && dn_rise_i && !up_rise_i) |=> (cnt_q == $past(cnt_q) - ONE));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && load_n_i && (up_rise_i == dn_rise_i)) |=> $stable(cnt_q));
endmodule

// File: rtl/flag_gen.sv
module flag_gen #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cnt_i,
  input  logic             up_lvl_i,
  input  logic             dn_lvl_i,
  output logic             carry_n_o,
  output logic             borrow_n_o
);
  logic at_top;
  logic at_bottom;

  always_comb begin
    at_top     = &cnt_i;
    at_bottom  = ~|cnt_i;
    carry_n_o  = ~(at_top & ~up_lvl_i);
    borrow_n_o = ~(at_bottom & ~dn_lvl_i);
  end
endmodule

// File: rtl/updn_dual_strobe_counter.sv
module updn_dual_strobe_counter #(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             load_n_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             up_strobe_i,
  input  logic             dn_strobe_i,
  output logic [WIDTH-1:0] q_o,
  output logic             carry_n_o,
  output logic             borrow_n_o
);
  logic [1:0] rst_q;
  logic       rst_sync_n;
  logic       up_lvl, up_rise;
  logic       dn_lvl, dn_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  strobe_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_up_det (
    .clk(clk), .rst_n(rst_sync_n), .line_i(up_strobe_i),
    .line_s_o(up_lvl), .rise_o(up_rise)
  );

  strobe_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_dn_det (
    .clk(clk), .rst_n(rst_sync_n), .line_i(dn_strobe_i),
    .line_s_o(dn_lvl), .rise_o(dn_rise)
  );

  count_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .clear_i(clear_i), .load_n_i(load_n_i),
    .data_i(data_i), .up_rise_i(up_rise), .dn_rise_i(dn_rise), .cnt_o(q_o)
  );

  flag_gen #(.WIDTH(WIDTH)) u_flags (
    .cnt_i(q_o), .up_lvl_i(up_lvl), .dn_lvl_i(dn_lvl),
    .carry_n_o(carry_n_o), .borrow_n_o(borrow_n_o)
  );

  // R8
  carry_top_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !carry_n_o |-> ((q_o == '1) && !up_lvl));
  // R9
  borrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !borrow_n_o |-> ((q_o == '0) && !dn_lvl));
  // R12
  fall_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clear_i && load_n_i && !up_rise && !dn_rise) |=> $stable(q_o));
endmodule

// File: tb/tb_updn_dual_strobe_counter.sv
module tb_updn_dual_strobe_counter;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         clear_i;
  logic         load_n_i;
  logic [W-1:0] data_i;
  logic         up_strobe_i;
  logic         dn_strobe_i;
  logic [W-1:0] q_o;
  logic         carry_n_o;
  logic         borrow_n_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [W-1:0] exp_q;

  always #2 clk = ~clk;

  updn_dual_strobe_counter #(.WIDTH(W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .load_n_i(load_n_i),
    .data_i(data_i), .up_strobe_i(up_strobe_i), .dn_strobe_i(dn_strobe_i),
    .q_o(q_o), .carry_n_o(carry_n_o), .borrow_n_o(borrow_n_o)
  );

  task automatic chk(input string req, input int act, input int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one low pulse on the chosen strobe; checks flags and stable count while low
  task automatic pulse(input bit up);
    if (up) up_strobe_i = 1'b0; else dn_strobe_i = 1'b0;
    wait_n(4);
    chk("R12 count held while strobe low", q_o, exp_q);
    chk("R8 carry", carry_n_o, (up && exp_q == 4'hF) ? 0 : 1);
    chk("R9 borrow", borrow_n_o, (!up && exp_q == 4'h0) ? 0 : 1);
    if (up) up_strobe_i = 1'b1; else dn_strobe_i = 1'b1;
    wait_n(4);
    if (up) exp_q = exp_q + 4'd1; else exp_q = exp_q - 4'd1;
    chk(up ? "R2 up step" : "R3 down step", q_o, exp_q);
    chk("R8 R9 flags idle", {carry_n_o, borrow_n_o}, 3);
  endtask

  task automatic do_load(input logic [W-1:0] v);
    load_n_i = 1'b0;
    data_i   = v;
    wait_n(2);
    load_n_i = 1'b1;
    wait_n(2);
    exp_q = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clear_i = 1'b0; load_n_i = 1'b1; data_i = '0;
    up_strobe_i = 1'b1; dn_strobe_i = 1'b1;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
    exp_q = '0;
    // R1
    chk("R1 reset count", q_o, 0);
    chk("R1 reset carry", carry_n_o, 1);
    chk("R1 reset borrow", borrow_n_o, 1);

    // R2 R4: full up sweep, last pulse wraps 15 -> 0
    for (int i = 0; i < 16; i++) pulse(1'b1);
    chk("R4 up wrap to zero", q_o, 0);
    // R3 R4: full down sweep, first pulse wraps 0 -> 15
    for (int i = 0; i < 16; i++) begin
      pulse(1'b0);
      if (i == 0) chk("R4 down wrap to all ones", q_o, 15);
    end

    // R5 R6: load every value, strobe during load, then count from it
    for (int v = 0; v < 16; v++) begin
      load_n_i = 1'b0;
      data_i   = v[W-1:0];
      wait_n(2);
      chk("R5 load value", q_o, v);
      up_strobe_i = 1'b0; wait_n(4); up_strobe_i = 1'b1; wait_n(4);
      dn_strobe_i = 1'b0; wait_n(4); dn_strobe_i = 1'b1; wait_n(4);
      chk("R6 strobes ignored during load", q_o, v);
      load_n_i = 1'b1;
      wait_n(2);
      chk("R5 value kept after load", q_o, v);
      exp_q = v[W-1:0];
      pulse(1'b1);
      pulse(1'b0);
      chk("R5 count resumes from load", q_o, v);
    end

    // R7: clear wins over load
    load_n_i = 1'b0; data_i = 4'd9; clear_i = 1'b1;
    wait_n(2);
    chk("R7 clear over load", q_o, 0);
    clear_i = 1'b0;
    wait_n(2);
    chk("R7 load after clear drops", q_o, 9);
    load_n_i = 1'b1;
    wait_n(2);
    do_load(4'd6);
    clear_i = 1'b1; wait_n(2); clear_i = 1'b0; wait_n(2);
    chk("R7 clear alone", q_o, 0);
    exp_q = '0;

    // R10: coincident rising edges cancel
    do_load(4'd9);
    up_strobe_i = 1'b0; dn_strobe_i = 1'b0;
    wait_n(4);
    up_strobe_i = 1'b1; dn_strobe_i = 1'b1;
    wait_n(4);
    chk("R10 coincident edges hold", q_o, 9);

    // R11: bit order
    do_load(4'b0001);
    chk("R11 lsb set", q_o[0], 1);
    chk("R11 upper bits clear", q_o[3:1], 0);
    do_load(4'b1000);
    chk("R11 msb set", q_o[3], 1);
    chk("R11 lower bits clear", q_o[2:0], 0);
    pulse(1'b0);
    chk("R11 borrow across bits", q_o, 7);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule